// File: doc/BRIEF.md
# Prescaled System Timer with Compare Channels

This block is a general-purpose time base. A single 32-bit up counter advances once every N system clock cycles, with N chosen by software between 1 and 256. The counter runs only while its enable bit is set. When the debug-mode input is high and the freeze bit is set, the counter stops.

Four compare channels share this counter. When an enabled channel's compare value equals the value the counter has just taken, the channel sets a sticky flag. The flag drives that channel's interrupt output until software writes a 1 to it.

Software reaches every register through a plain register port. The port has a write strobe, a word address, write data and combinational read data.

Register map, by word address:
- Address 0 is the control word: bit 0 is the timer enable, bit 1 is the debug freeze, and bits 15:8 hold the prescale field.
- Address 1 is the counter.
- Channel i occupies addresses 4+4i to 4+4i+2:
  - offset 0 is the channel enable (bit 0);
  - offset 1 is the flag (bit 0);
  - offset 2 is the 32-bit compare value.
- Every other address, and every unused bit, reads as zero.

Top module: `sys_timer`

## Requirements
- R1: After reset, every register reads zero and all four interrupt outputs are low.
- R2: While the timer is enabled and not frozen, with prescale field k (bits 15:8 of address 0), the counter grows by exactly one every k+1 clock cycles. While the timer is disabled, the counter holds its value.
- R3: Disabling the timer clears the prescale phase. After the enable is written, the first increment lands k+1 cycles later.
- R4: With debug mode high and freeze (bit 1 of address 0) set, the counter holds. With debug mode low, or with freeze clear, the counter keeps counting.
- R5: The counter wraps from 0xFFFF_FFFF to 0x0000_0000 and continues counting normally.
- R6: A channel sets its flag, and asserts its interrupt output, on the clock where the counter takes a value equal to the channel's compare register. The counter takes a value either by incrementing or by a software load. A counter that merely holds a matching value sets nothing.
- R7: A channel whose enable bit is 0 never sets its flag.
- R8: Writing 1 to a channel's flag bit clears the flag and its interrupt. Writing 0 leaves the flag unchanged.
- R9: If a flag set and a write-one-to-clear fall on the same clock, the flag ends up set.
- R10: Software can write the counter. The control word, the channel enables and the compare values read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_mode | input | 1 | Debug mode indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational) |
| irq | output | 4 | Per-channel interrupt requests |

## Verification
The bench measures the cycle of the first increment after enabling, for prescale values 0, 3 and 255. It also re-enables the timer after a mid-period disable. A divider that is off by one, or that keeps its phase across a disable, shows up as a wrong count at a known cycle.

Other tests cover the wrap past all ones, and freeze applied with and without debug mode. One test writes a compare value equal to a counter that is standing still; a level-sensitive comparator would set the flag there.

The flag tests cover several bad designs:
- a disabled channel that still matches;
- a write of 0 that clears the flag;
- a clear that wins over a same-cycle set, which loses the interrupt.

// File: rtl/st_pkg.sv
package st_pkg;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned PSC_W = 8;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_CNT  = 1;
  localparam int unsigned OFF_EN   = 0;
  localparam int unsigned OFF_FLAG = 1;
  localparam int unsigned OFF_CMP  = 2;

  function automatic int unsigned chan_addr(int unsigned ch, int unsigned off);
    return 4 + 4 * ch + off;
  endfunction

  function automatic logic [CNT_W-1:0] count_step(logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic is_match(logic en, logic [CNT_W-1:0] v, logic [CNT_W-1:0] cmp);
    return en && (v == cmp);
  endfunction
endpackage

// File: rtl/st_prescale.sv
module st_prescale #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] phase;
  logic             run;

  assign run  = en && !hold;
  assign tick = run && (phase >= psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (!en)    phase <= '0;
    else if (run)    phase <= tick ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/st_channel.sv
module st_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             en_d,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_d,
  input  logic             flag_clr,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             cen,
  output logic [CNT_W-1:0] cmp,
  output logic             flag,
  output logic             hit
);
  import st_pkg::*;

  assign hit = cnt_load && is_match(cen, cnt_nxt, cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen  <= 1'b0;
      cmp  <= '0;
      flag <= 1'b0;
    end else begin
      if (en_we)  cen <= en_d;
      if (cmp_we) cmp <= cmp_d;
      flag <= hit || (flag && !flag_clr);
    end
  end
endmodule

// File: rtl/sys_timer.sv
module sys_timer #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8,
  localparam int unsigned ADDR_W = $clog2(4 + 4 * NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NCH-1:0]    irq
);
  import st_pkg::*;

  logic             ten, frz;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             ctrl_wr, cnt_wr, tick, cnt_load;
  logic [NCH-1:0]   cen_v, flag_v, hit_v;
  logic [CNT_W-1:0] cmp_v [NCH];

  assign ctrl_wr  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign cnt_wr   = wr_en && (addr == ADDR_W'(A_CNT));
  assign cnt_load = cnt_wr || tick;
  assign cnt_nxt  = cnt_wr ? wdata : count_step(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten   <= 1'b0;
      frz   <= 1'b0;
      psc   <= '0;
      cnt_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ten <= wdata[0];
        frz <= wdata[1];
        psc <= wdata[8 +: PSC_W];
      end
      if (cnt_load) cnt_q <= cnt_nxt;
    end
  end

  st_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(ten), .hold(dbg_mode && frz),
    .psc(psc), .tick(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic en_we, cmp_we, clr;
    assign en_we  = wr_en && (addr == ADDR_W'(chan_addr(i, OFF_EN)));
    assign cmp_we = wr_en && (addr == ADDR_W'(chan_addr(i, OFF_CMP)));
    assign clr    = wr_en && (addr == ADDR_W'(chan_addr(i, OFF_FLAG))) && wdata[0];

    st_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .en_we(en_we), .en_d(wdata[0]),
      .cmp_we(cmp_we), .cmp_d(wdata),
      .flag_clr(clr), .cnt_load(cnt_load), .cnt_nxt(cnt_nxt),
      .cen(cen_v[i]), .cmp(cmp_v[i]), .flag(flag_v[i]), .hit(hit_v[i])
    );
  end

  assign irq = flag_v;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL)) begin
      rdata[0]           = ten;
      rdata[1]           = frz;
      rdata[8 +: PSC_W]  = psc;
    end
    if (addr == ADDR_W'(A_CNT)) rdata = cnt_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(chan_addr(i, OFF_EN)))   rdata = {{(CNT_W-1){1'b0}}, cen_v[i]};
      if (addr == ADDR_W'(chan_addr(i, OFF_FLAG))) rdata = {{(CNT_W-1){1'b0}}, flag_v[i]};
      if (addr == ADDR_W'(chan_addr(i, OFF_CMP)))  rdata = cmp_v[i];
    end
  end
endmodule

// File: rtl/st_checker.sv
module st_checker #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_mode,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [NCH-1:0]    irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              tick,
  input logic              cnt_wr,
  input logic              ten,
  input logic              frz,
  input logic [NCH-1:0]    cen_v,
  input logic [NCH-1:0]    hit_v
);
  import st_pkg::*;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));
  assert_off_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ten |-> !tick);
  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && frz) |-> !tick);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && (cnt_q == '1)) |=> (cnt_q == '0));
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata)));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic clr;
    assign clr = wr_en && (addr == ADDR_W'(chan_addr(i, OFF_FLAG))) && wdata[0];

    assert_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_v[i] |=> irq[i]);
    assert_rise_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(hit_v[i]));
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cen_v[i] |-> !hit_v[i]);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !clr) |=> irq[i]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_v[i] && clr) |=> irq[i]);
  end
endmodule

bind sys_timer st_checker #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .cnt_q(cnt_q), .tick(tick), .cnt_wr(cnt_wr),
  .ten(ten), .frz(frz), .cen_v(cen_v), .hit_v(hit_v)
);

// File: tb/sys_timer_bench.sv
module sys_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int checks = 0;
  int errors = 0;

  sys_timer u_sys_timer (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  localparam logic [4:0] CTRL = 5'd0, CNT = 5'd1;
  function automatic logic [4:0] ca(int ch, int off);
    return 5'(4 + 4 * ch + off);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(CTRL, v); chk("R1 ctrl", v, 0);
    rd(CNT, v);  chk("R1 cnt", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(ca(i, 0), v); chk("R1 chan en", v, 0);
      rd(ca(i, 1), v); chk("R1 chan flag", v, 0);
      rd(ca(i, 2), v); chk("R1 chan cmp", v, 0);
    end
    chk("R1 irq", {28'd0, irq}, 0);
  endtask

  task automatic t_prescale(int k);
    logic [31:0] v;
    wr(CTRL, 0); wr(CNT, 0);
    wr(CTRL, 32'h1 | (k << 8));
    for (int n = 1; n <= 3 * (k + 1); n++) begin
      @(negedge clk);
      rd(CNT, v);
      chk("R2 R3 prescaled count", v, 32'(n / (k + 1)));
    end
    rd(CTRL, v); chk("R10 ctrl readback", v, 32'h1 | (k << 8));
  endtask

  task automatic t_restart();
    logic [31:0] v, w;
    wr(CTRL, 0); wr(CNT, 0);
    wr(CTRL, 32'h1 | (4 << 8));
    waitn(7);
    wr(CTRL, 0);
    rd(CNT, v);
    waitn(10);
    rd(CNT, w); chk("R2 hold while disabled", w, v);
    wr(CTRL, 32'h1 | (4 << 8));
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      rd(CNT, w);
      chk("R3 phase cleared by disable", w, (n == 5) ? v + 1 : v);
    end
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(CTRL, 0); wr(CNT, 32'hFFFF_FFFE);
    rd(CNT, v); chk("R10 counter load", v, 32'hFFFF_FFFE);
    wr(CTRL, 32'h1);
    waitn(1); rd(CNT, v); chk("R5 reach max", v, 32'hFFFF_FFFF);
    waitn(1); rd(CNT, v); chk("R5 wrap to zero", v, 32'h0);
    waitn(1); rd(CNT, v); chk("R5 after wrap", v, 32'h1);
  endtask

  task automatic t_freeze();
    logic [31:0] v, w;
    wr(CTRL, 0); wr(CNT, 0);
    dbg_mode = 1'b1;
    wr(CTRL, 32'h3);
    waitn(5); rd(CNT, v); chk("R4 frozen in debug", v, 0);
    dbg_mode = 1'b0;
    waitn(5); rd(CNT, v); chk("R4 runs outside debug", v, 5);
    dbg_mode = 1'b1;
    wr(CTRL, 32'h1);
    rd(CNT, v);
    waitn(4); rd(CNT, w); chk("R4 runs in debug without freeze", w, v + 4);
    dbg_mode = 1'b0;
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(CTRL, 0); wr(CNT, 100);
    wr(ca(0, 2), 103); wr(ca(0, 0), 1);
    wr(ca(1, 2), 103);
    rd(ca(0, 2), v); chk("R10 cmp readback", v, 103);
    rd(ca(0, 0), v); chk("R10 enable readback", v, 1);
    wr(CTRL, 32'h1);
    waitn(1); chk("R6 no flag before match", {31'd0, irq[0]}, 0);
    waitn(1); chk("R6 no flag before match", {31'd0, irq[0]}, 0);
    waitn(1); chk("R6 flag at match", {31'd0, irq[0]}, 1);
    rd(ca(0, 1), v); chk("R6 flag readback", v, 1);
    chk("R7 disabled channel quiet", {31'd0, irq[1]}, 0);
    wr(ca(0, 1), 0);
    chk("R8 write zero keeps flag", {31'd0, irq[0]}, 1);
    wr(ca(0, 1), 1);
    chk("R8 write one clears flag", {31'd0, irq[0]}, 0);
    waitn(3);
    chk("R8 stays clear", {31'd0, irq[0]}, 0);
    chk("R7 disabled channel still quiet", {31'd0, irq[1]}, 0);
  endtask

  task automatic t_set_priority();
    wr(CTRL, 0); wr(CNT, 200);
    wr(ca(2, 2), 202); wr(ca(2, 0), 1);
    wr(CTRL, 32'h1);
    wr(ca(2, 1), 1);
    chk("R9 set wins over clear", {31'd0, irq[2]}, 1);
    waitn(2);
    chk("R9 flag stays set", {31'd0, irq[2]}, 1);
    wr(ca(2, 1), 1);
  endtask

  task automatic t_static_match();
    logic [31:0] v;
    wr(CTRL, 0); wr(CNT, 300);
    wr(ca(3, 2), 300); wr(ca(3, 0), 1);
    waitn(3);
    chk("R6 held counter sets nothing", {31'd0, irq[3]}, 0);
    wr(CNT, 300);
    chk("R6 counter load matches", {31'd0, irq[3]}, 1);
    rd(CNT, v); chk("R10 counter load value", v, 300);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitn(3);
    t_reset();
    rst_n = 1'b1;
    waitn(1);
    t_reset();
    t_prescale(0);
    t_prescale(3);
    t_prescale(255);
    t_restart();
    t_wrap();
    t_freeze();
    t_match();
    t_set_priority();
    t_static_match();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule